// File: doc/BRIEF.md
# Register-Pair Stack Push/Pop Sequencer

This block carries out the one-byte stack instructions that save a 16-bit register pair to byte-wide memory or restore it from there. It owns the eight working byte registers, grouped as the pairs BC, DE, HL and accumulator/flags, together with a 16-bit stack pointer. An opcode that has already been fetched is presented with a one-cycle start strobe. The block then counts the instruction's clock states, runs two memory data cycles over a plain address, data and read/write strobe interface, and updates the pair and the stack pointer at the end of the instruction.

Every clock is one state. State 1 is the cycle after the start strobe. The fetch portion is idle because the opcode is already in hand: six states for a push and four for a pop. Two memory cycles of three states each follow. In each memory cycle the address is held for all three states, and the strobe is raised only in the middle state. Read data is sampled at the end of that middle state. A load strobe presets the stack pointer and all four pairs while the block is idle, and every register is visible on output ports.

Top module: `rp_stack_seq`

## Requirements
- R1: After reset the stack pointer and all four pairs read 0000, and busy, done, illegal, mem_rd and mem_wr are low.
- R2: load_en while idle copies load_sp and the four load_* pair values into the registers at the next clock edge. load_en while busy has no effect.
- R3: Opcode bits 5:4 select the pair: 00 BC, 01 DE, 10 HL, 11 accumulator/flags. In the accumulator/flags pair, the accumulator is bits 15:8 and the flags register is bits 7:0.
- R4: A push (opcodes C5, D5, E5, F5 hex) writes the high byte to SP-1 in its first memory cycle and the low byte to SP-2 in its second. It leaves the stack pointer at SP-2 and never writes at or above the starting stack pointer.
- R5: A pop (opcodes C1, D1, E1, F1 hex) reads the low byte from SP in its first memory cycle and the high byte from SP+1 in its second. It loads the pair with both bytes and leaves the stack pointer at SP+2.
- R6: A push lasts 12 states: the write strobe is high in states 8 and 11, and done is high in state 12.
- R7: A pop lasts 10 states: the read strobe is high in states 6 and 9, and done is high in state 10.
- R8: Stack pointer arithmetic, for both addresses and the final value, wraps modulo 65536.
- R9: A start with any other opcode raises illegal for one cycle after the strobe. It starts no memory cycle and changes no register.
- R10: A start strobe while busy is ignored. The running instruction keeps its state count, addresses and result.
- R11: mem_rd and mem_wr are never high together. Each strobe lasts exactly one state, and the address is held steady through each three-state memory cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Preset strobe for stack pointer and pairs (idle only) |
| load_sp | input | 16 | Stack pointer preset value |
| load_bc | input | 16 | BC preset value |
| load_de | input | 16 | DE preset value |
| load_hl | input | 16 | HL preset value |
| load_af | input | 16 | Accumulator (high) / flags (low) preset value |
| start | input | 1 | One-cycle strobe: opcode is valid |
| opcode | input | 8 | Fetched opcode byte |
| mem_addr | output | 16 | Memory address during a memory cycle, else 0 |
| mem_wdata | output | 8 | Write data during a push memory cycle, else 0 |
| mem_rdata | input | 8 | Read data, sampled at the end of the read strobe state |
| mem_rd | output | 1 | Read strobe, one state wide |
| mem_wr | output | 1 | Write strobe, one state wide |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | High in the final state of an instruction |
| illegal | output | 1 | One-cycle flag for an unsupported opcode |
| state_cnt | output | 4 | Current state number, 0 when idle |
| sp_val | output | 16 | Stack pointer |
| bc_val | output | 16 | BC pair |
| de_val | output | 16 | DE pair |
| hl_val | output | 16 | HL pair |
| af_val | output | 16 | Accumulator/flags pair |

## Verification
Two situations are the hardest to reach from the ports. The first is a second start strobe that lands in the middle of a running instruction. The stimulus raises start with a legal push opcode two states into an instruction and expects the memory trace and final registers of the first instruction alone. The second is the wrap of the stack pointer across 0000/FFFF. The stimulus reaches it by presetting the stack pointer to 0001 and to FFFF and then pushing and popping, so that both byte addresses of one instruction sit on opposite sides of the wrap.

// File: rtl/rps_pkg.sv
package rps_pkg;

  localparam int RPS_AW = 16;

  typedef enum logic [1:0] {
    PR_BC = 2'b00,
    PR_DE = 2'b01,
    PR_HL = 2'b10,
    PR_AF = 2'b11
  } pair_e;

  // Stack pointer arithmetic, wrapping modulo 2^RPS_AW.
  function automatic logic [RPS_AW-1:0] sp_sub(input logic [RPS_AW-1:0] v, input int unsigned n);
    return v - RPS_AW'(n);
  endfunction

  function automatic logic [RPS_AW-1:0] sp_add(input logic [RPS_AW-1:0] v, input int unsigned n);
    return v + RPS_AW'(n);
  endfunction

endpackage

// File: rtl/rps_decode.sv
module rps_decode
  import rps_pkg::*;
(
  input  logic [7:0] op,
  output logic       legal,
  output logic       is_push,
  output pair_e      pair
);
  // Pattern 11pp0101 is a push, 11pp0001 is a pop.
  logic top_ok, low_push, low_pop;

  always_comb begin
    top_ok   = (op[7:6] == 2'b11);
    low_push = (op[3:0] == 4'b0101);
    low_pop  = (op[3:0] == 4'b0001);
    legal    = top_ok && (low_push || low_pop);
    is_push  = low_push;
    pair     = pair_e'(op[5:4]);
  end
endmodule

// File: rtl/rps_timer.sv
module rps_timer #(
  parameter int CW     = 4,
  parameter int PUSH_T = 12,
  parameter int POP_T  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_push,
  output logic [CW-1:0] cnt,
  output logic          busy,
  output logic          last
);
  localparam logic [CW-1:0] PUSH_C = CW'(PUSH_T);
  localparam logic [CW-1:0] POP_C  = CW'(POP_T);

  logic [CW-1:0] tot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tot_q <= '0;
    end else if (go) begin
      cnt   <= CW'(1);
      tot_q <= go_push ? PUSH_C : POP_C;
    end else if (busy) begin
      cnt <= last ? '0 : cnt + CW'(1);
    end
  end

  assign busy = (cnt != '0);
  assign last = busy && (cnt == tot_q);

  // R10: a running instruction advances one state per clock, whatever start does.
  a_r10_advance: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> cnt == CW'($past(cnt) + CW'(1)));

  // R6 / R7: the final state is state 12 for a push or state 10 for a pop.
  a_r6_final_len: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (cnt == PUSH_C || cnt == POP_C));

  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !busy);
endmodule

// File: rtl/rps_regfile.sv
module rps_regfile #(
  parameter int AW = 16,
  parameter int PW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [AW-1:0]       load_sp,
  input  logic [3:0][PW-1:0]  load_pairs,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [PW-1:0]       wr_val,
  input  logic                sp_en,
  input  logic [AW-1:0]       sp_next,
  output logic [AW-1:0]       sp,
  output logic [3:0][PW-1:0]  pairs
);
  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= '0;
    else if (load_en) sp <= load_sp;
    else if (sp_en)   sp <= sp_next;
  end

  for (genvar g = 0; g < 4; g++) begin : g_pair
    always_ff @(posedge clk) begin
      if (!rst_n)                               pairs[g] <= '0;
      else if (load_en)                         pairs[g] <= load_pairs[g];
      else if (wr_en && (wr_sel == 2'(g)))      pairs[g] <= wr_val;
    end
  end

  // R2: a preset lands in the stack pointer on the next edge.
  a_r2_preset_sp: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> sp == $past(load_sp));
endmodule

// File: rtl/rp_stack_seq.sv
module rp_stack_seq
  import rps_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CW      = 4,
  parameter int MEM_T   = 3,
  parameter int STB_POS = 1,
  parameter int PUSH_T  = 12,
  parameter int POP_T   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [RPS_AW-1:0]   load_sp,
  input  logic [2*DW-1:0]     load_bc,
  input  logic [2*DW-1:0]     load_de,
  input  logic [2*DW-1:0]     load_hl,
  input  logic [2*DW-1:0]     load_af,
  input  logic                start,
  input  logic [7:0]          opcode,
  output logic [RPS_AW-1:0]   mem_addr,
  output logic [DW-1:0]       mem_wdata,
  input  logic [DW-1:0]       mem_rdata,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic                busy,
  output logic                done,
  output logic                illegal,
  output logic [CW-1:0]       state_cnt,
  output logic [RPS_AW-1:0]   sp_val,
  output logic [2*DW-1:0]     bc_val,
  output logic [2*DW-1:0]     de_val,
  output logic [2*DW-1:0]     hl_val,
  output logic [2*DW-1:0]     af_val
);
  localparam int AW = RPS_AW;
  localparam int PW = 2 * DW;
  localparam logic [CW-1:0] FETCH_PUSH = CW'(PUSH_T - 2 * MEM_T);
  localparam logic [CW-1:0] FETCH_POP  = CW'(POP_T - 2 * MEM_T);
  localparam logic [CW-1:0] MEM_C      = CW'(MEM_T);
  localparam logic [CW-1:0] STB_C      = CW'(STB_POS);

  // Decode
  logic  legal, dec_push;
  pair_e dec_pair;

  rps_decode u_dec (
    .op      (opcode),
    .legal   (legal),
    .is_push (dec_push),
    .pair    (dec_pair)
  );

  // State counting
  logic          busy_i, last_i, go;
  logic [CW-1:0] cnt;

  assign go = start && !busy_i && legal;

  rps_timer #(.CW(CW), .PUSH_T(PUSH_T), .POP_T(POP_T)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .go_push (dec_push),
    .cnt     (cnt),
    .busy    (busy_i),
    .last    (last_i)
  );

  // Instruction latch
  logic  op_push_q;
  pair_e sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_push_q <= 1'b0;
      sel_q     <= PR_BC;
    end else if (go) begin
      op_push_q <= dec_push;
      sel_q     <= dec_pair;
    end
  end

  // Memory-cycle position within the instruction
  logic [CW-1:0] fetch_len, off, pos;
  logic          in_mem, second, strobe;

  always_comb begin
    fetch_len = op_push_q ? FETCH_PUSH : FETCH_POP;
    in_mem    = busy_i && (cnt > fetch_len);
    off       = cnt - fetch_len - CW'(1);
    second    = (off >= MEM_C);
    pos       = second ? (off - MEM_C) : off;
    strobe    = in_mem && (pos == STB_C);
  end

  // Registers
  logic [AW-1:0]      sp_q, sp_next;
  logic [3:0][PW-1:0] pairs;
  logic [PW-1:0]      src_pair;
  logic [DW-1:0]      lo_q, hi_q;
  logic               load_take, wr_en;

  assign load_take = load_en && !busy_i;
  assign src_pair  = pairs[sel_q];
  assign wr_en     = last_i && !op_push_q;
  assign sp_next   = op_push_q ? sp_sub(sp_q, 2) : sp_add(sp_q, 2);

  rps_regfile #(.AW(AW), .PW(PW)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_take),
    .load_sp    (load_sp),
    .load_pairs ({load_af, load_hl, load_de, load_bc}),
    .wr_en      (wr_en),
    .wr_sel     (sel_q),
    .wr_val     ({hi_q, lo_q}),
    .sp_en      (last_i),
    .sp_next    (sp_next),
    .sp         (sp_q),
    .pairs      (pairs)
  );

  // Read capture at the end of the strobe state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (strobe && !op_push_q) begin
      if (second) hi_q <= mem_rdata;
      else        lo_q <= mem_rdata;
    end
  end

  // Memory interface
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (in_mem) begin
      if (op_push_q) begin
        mem_addr  = second ? sp_sub(sp_q, 2) : sp_sub(sp_q, 1);
        mem_wdata = second ? src_pair[DW-1:0] : src_pair[PW-1:DW];
      end else begin
        mem_addr  = second ? sp_add(sp_q, 1) : sp_q;
      end
    end
  end

  assign mem_wr = strobe && op_push_q;
  assign mem_rd = strobe && !op_push_q;

  // Illegal flag
  logic ill_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= start && !busy_i && !legal;
  end

  assign illegal   = ill_q;
  assign busy      = busy_i;
  assign done      = last_i;
  assign state_cnt = cnt;
  assign sp_val    = sp_q;
  assign bc_val    = pairs[0];
  assign de_val    = pairs[1];
  assign hl_val    = pairs[2];
  assign af_val    = pairs[3];

  // R11: read and write strobes are exclusive, each one state wide.
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  a_r11_wr_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);
  a_r11_rd_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |=> $stable(mem_addr));

  // R4: a push writes only the two bytes just below the stack pointer.
  a_r4_push_below_sp: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (AW'(sp_q - mem_addr) == AW'(1) || AW'(sp_q - mem_addr) == AW'(2)));

  // R5: a pop reads only at SP and SP+1.
  a_r5_pop_live_area: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (AW'(mem_addr - sp_q) <= AW'(1)));

  // R8: the stack pointer moves by two with wrap at the end of an instruction.
  a_r8_push_sp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_push_q |=> sp_val == sp_sub($past(sp_val), 2));
  a_r8_pop_sp_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_push_q |=> sp_val == sp_add($past(sp_val), 2));

  // R9: an illegal opcode starts nothing.
  a_r9_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !mem_rd && !mem_wr));
endmodule

// File: tb/rp_stack_seq_bench.sv
`timescale 1ns/1ps
module rp_stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_sp = '0, load_bc = '0, load_de = '0, load_hl = '0, load_af = '0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, busy, done, illegal;
  logic [3:0]  state_cnt;
  logic [15:0] sp_val, bc_val, de_val, hl_val, af_val;

  always #2 clk = ~clk;

  rp_stack_seq u_rp_stack_seq (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sp(load_sp),
    .load_bc(load_bc), .load_de(load_de), .load_hl(load_hl), .load_af(load_af),
    .start(start), .opcode(opcode), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy),
    .done(done), .illegal(illegal), .state_cnt(state_cnt), .sp_val(sp_val),
    .bc_val(bc_val), .de_val(de_val), .hl_val(hl_val), .af_val(af_val)
  );

  // Memory seen by the design (indexed by the low address byte) and the bench model.
  logic [7:0] bmem [256];
  logic [7:0] exp_mem [256];
  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) bmem[mem_addr[7:0]] <= mem_wdata;

  int n_chk = 0, n_bad = 0;
  int cycle = 0, t0 = 0;
  always @(posedge clk) cycle <= cycle + 1;

  logic [15:0] m_sp;
  logic [15:0] m_pair [4];

  typedef struct {
    bit          wr;
    logic [15:0] a;
    logic [7:0]  d;
    int          st;
    string       req;
  } ev_t;
  ev_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Monitor: compares every strobe against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr)) begin
      if (mem_rd && mem_wr) chk(1'b0, "R11", "rd and wr together", 32'd1, 32'd0);
      if (q.size() == 0) begin
        chk(1'b0, "R11", "unexpected strobe at addr", {16'd0, mem_addr}, 32'd0);
      end else begin
        ev_t e;
        e = q.pop_front();
        chk(mem_wr == e.wr, e.req, "strobe kind (1=wr)", {31'd0, mem_wr}, {31'd0, e.wr});
        chk(mem_addr == e.a, e.req, "address", {16'd0, mem_addr}, {16'd0, e.a});
        chk((cycle - t0) == e.st, e.req, "strobe state", cycle - t0, e.st);
        if (e.wr) chk(mem_wdata == e.d, e.req, "write data", {24'd0, mem_wdata}, {24'd0, e.d});
      end
    end
  end

  task automatic check_regs(input string req);
    chk(sp_val == m_sp, req, "sp", {16'd0, sp_val}, {16'd0, m_sp});
    chk(bc_val == m_pair[0], req, "bc", {16'd0, bc_val}, {16'd0, m_pair[0]});
    chk(de_val == m_pair[1], req, "de", {16'd0, de_val}, {16'd0, m_pair[1]});
    chk(hl_val == m_pair[2], req, "hl", {16'd0, hl_val}, {16'd0, m_pair[2]});
    chk(af_val == m_pair[3], req, "af", {16'd0, af_val}, {16'd0, m_pair[3]});
  endtask

  task automatic do_load(input logic [15:0] s, input logic [15:0] b, input logic [15:0] d,
                         input logic [15:0] h, input logic [15:0] a);
    @(negedge clk);
    load_en = 1'b1; load_sp = s; load_bc = b; load_de = d; load_hl = h; load_af = a;
    @(negedge clk);
    load_en = 1'b0;
    m_sp = s; m_pair[0] = b; m_pair[1] = d; m_pair[2] = h; m_pair[3] = a;
    check_regs("R2");
  endtask

  // Driver: predicts the memory trace and final state, then runs the opcode.
  task automatic run_op(input logic [7:0] op, input bit disturb, input string req);
    bit          is_push, is_legal;
    int          p, tot, n;
    logic [15:0] sp0, v;
    logic [7:0]  lo, hi;
    is_legal = (op[7:6] == 2'b11) && (op[3:0] == 4'h5 || op[3:0] == 4'h1);
    is_push  = (op[3:0] == 4'h5);
    p   = int'(op[5:4]);
    sp0 = m_sp;
    if (!is_legal) begin
      @(negedge clk); start = 1'b1; opcode = op; t0 = cycle;
      @(negedge clk); start = 1'b0;
      chk(illegal == 1'b1, "R9", "illegal flag", {31'd0, illegal}, 32'd1);
      chk(busy == 1'b0, "R9", "busy after illegal", {31'd0, busy}, 32'd0);
      repeat (3) @(negedge clk);
      chk(illegal == 1'b0, "R9", "illegal one cycle", {31'd0, illegal}, 32'd0);
      check_regs("R9");
      return;
    end
    if (is_push) begin
      v = m_pair[p];
      q.push_back('{1'b1, sp0 - 16'd1, v[15:8], 8, "R4"});
      q.push_back('{1'b1, sp0 - 16'd2, v[7:0], 11, "R4"});
      exp_mem[8'(sp0 - 16'd1)] = v[15:8];
      exp_mem[8'(sp0 - 16'd2)] = v[7:0];
      m_sp = sp0 - 16'd2;
      tot  = 12;
    end else begin
      lo = exp_mem[8'(sp0)];
      hi = exp_mem[8'(sp0 + 16'd1)];
      q.push_back('{1'b0, sp0, 8'h00, 6, "R5"});
      q.push_back('{1'b0, sp0 + 16'd1, 8'h00, 9, "R5"});
      m_pair[p] = {hi, lo};
      m_sp = sp0 + 16'd2;
      tot  = 10;
    end
    @(negedge clk); start = 1'b1; opcode = op; t0 = cycle;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, req, "busy in state 1", {31'd0, busy}, 32'd1);
    if (disturb) begin
      // R10: a legal push strobe in state 2 must be ignored.
      start = 1'b1; opcode = 8'hD5;
      @(negedge clk); start = 1'b0;
    end
    n = 0;
    while (!done && n < 40) begin @(negedge clk); n++; end
    chk(done == 1'b1, is_push ? "R6" : "R7", "done seen", {31'd0, done}, 32'd1);
    chk((cycle - t0) == tot, is_push ? "R6" : "R7", "done state", cycle - t0, tot);
    @(negedge clk);
    chk(busy == 1'b0, req, "idle after done", {31'd0, busy}, 32'd0);
    chk(q.size() == 0, "R11", "missing strobes", q.size(), 32'd0);
    check_regs(req);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin bmem[i] = 8'h00; exp_mem[i] = 8'h00; end
    m_sp = '0;
    for (int i = 0; i < 4; i++) m_pair[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_regs("R1");
    chk({busy, done, illegal, mem_rd, mem_wr} == 5'b0, "R1", "control outputs",
        {27'd0, busy, done, illegal, mem_rd, mem_wr}, 32'd0);

    do_load(16'h4000, 16'hAABB, 16'h1234, 16'h5678, 16'h9ABC);
    run_op(8'hC5, 1'b0, "R4");   // push BC
    run_op(8'hD1, 1'b0, "R5");   // pop into DE: DE = AABB, SP = 4000
    chk(de_val == 16'hAABB, "R5", "de after pop", {16'd0, de_val}, 32'hAABB);
    // R3: accumulator is the high byte of the pushed pair
    run_op(8'hF5, 1'b0, "R3");
    run_op(8'hE1, 1'b0, "R3");
    chk(hl_val == 16'h9ABC, "R3", "hl from af", {16'd0, hl_val}, 32'h9ABC);
    run_op(8'hE5, 1'b0, "R3");
    run_op(8'hD5, 1'b0, "R3");
    run_op(8'hC1, 1'b0, "R3");
    run_op(8'hF1, 1'b0, "R3");

    // R10: start while busy
    run_op(8'hC5, 1'b1, "R10");
    run_op(8'hE1, 1'b1, "R10");

    // R9: illegal opcodes
    run_op(8'hC3, 1'b0, "R9");
    run_op(8'h00, 1'b0, "R9");
    run_op(8'hC9, 1'b0, "R9");

    // R8: wrap on push from 0001 and on pop from FFFF
    do_load(16'h0001, 16'h3C4D, 16'h0000, 16'h0000, 16'h0000);
    run_op(8'hC5, 1'b0, "R8");
    chk(sp_val == 16'hFFFF, "R8", "sp after wrap push", {16'd0, sp_val}, 32'hFFFF);
    run_op(8'hD1, 1'b0, "R8");
    chk(de_val == 16'h3C4D, "R8", "de after wrap pop", {16'd0, de_val}, 32'h3C4D);
    chk(sp_val == 16'h0001, "R8", "sp after wrap pop", {16'd0, sp_val}, 32'h0001);

    // R2: load while busy has no effect
    @(negedge clk); start = 1'b1; opcode = 8'hC5;
    q.push_back('{1'b1, m_sp - 16'd1, m_pair[0][15:8], 8, "R2"});
    q.push_back('{1'b1, m_sp - 16'd2, m_pair[0][7:0], 11, "R2"});
    exp_mem[8'(m_sp - 16'd1)] = m_pair[0][15:8];
    exp_mem[8'(m_sp - 16'd2)] = m_pair[0][7:0];
    t0 = cycle;
    @(negedge clk); start = 1'b0; load_en = 1'b1; load_sp = 16'h1111; load_bc = 16'h2222;
    @(negedge clk); load_en = 1'b0;
    m_sp = m_sp - 16'd2;
    while (!done) @(negedge clk);
    @(negedge clk);
    check_regs("R2");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule